// File: doc/BRIEF.md
# Sequential Floating-Point Multiplier

This block multiplies two 32-bit floating-point words over a short, fixed sequence of clock cycles. Each word holds a sign bit in the top position, an 8-bit exponent stored with an offset of 128, and a 23-bit fraction in the low bits. The fraction has an implied leading 1 that is not stored. The result has the same layout. Its sign is the exclusive-OR of the two operand signs. Its exponent is the sum of the operand exponents minus the offset. Its fraction comes from the 24-by-24-bit product of the significands, normalized by at most one place. Bits below the kept fraction are dropped without rounding.

A requester places both operands on the inputs and raises `req_i`. The operands only need to be valid on the clock edge at which the idle block first sees `req_i` high. Four clocks later `done_o` rises, and the result appears on `res_o` at the same time. `done_o` stays high for as long as `req_i` stays high. Once `req_i` falls, the block goes back to idle, and a new operation starts only on a fresh `req_i`. The block treats this four-phase request/done exchange as its only flow control. It has no data stream and no back-pressure beyond holding `req_i`.

When the exponent is too large, the result saturates to the largest magnitude with the correct sign, and `ovf_o` is raised alongside `done_o`. When the exponent is too small, the result is flushed to zero. The block does not handle special values, subnormals or rounding modes.

Top module: `fpmul_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `done_o` is 0, `ovf_o` is 0 and `res_o` is all zeros.
- R2: When the idle block samples `req_i` high on a rising edge, `done_o` stays 0 for the next three edges and becomes 1 after the fourth edge.
- R3: While `done_o` is 1, it stays 1 as long as `req_i` is 1, and it returns to 0 one edge after `req_i` is sampled low. No new operation starts until `req_i` rises again.
- R4: Bit 31 of a non-zero, non-flushed result equals bit 31 of A XOR bit 31 of B.
- R5: For non-zero operands, the significand product P is {1, A[22:0]} times {1, B[22:0]}, 48 bits wide. If P[47] is 1, the result fraction is P[46:24] and the exponent is A[30:23] + B[30:23] - 127. Otherwise the fraction is P[45:23] and the exponent is A[30:23] + B[30:23] - 128. A result exponent from 1 to 255 is stored unchanged in bits 30:23.
- R6: An operand with bits 30:0 all zero is zero. If either operand is zero, the result is 32'h00000000 and `ovf_o` is 0.
- R7: If the computed exponent is 0 or less, the result is 32'h00000000 and `ovf_o` is 0.
- R8: If the computed exponent exceeds 255, bits 30:0 of the result are all ones, bit 31 follows R4, and `ovf_o` is 1 on exactly the cycles when `done_o` is 1.
- R9: While `done_o` is 1, `res_o` and `ovf_o` do not change.
- R10: The result depends only on the operand values at the edge where the request is accepted. Later changes on `a_i` or `b_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request. Raised to start an operation, held until done, then dropped |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| res_o | output | 32 | Product, valid while done_o is high |
| done_o | output | 1 | Operation complete, held while req_i stays high |
| ovf_o | output | 1 | High with done_o when the result saturated |

## Verification
The checker watches the handshake on every cycle:
- the four-cycle latency from request to done;
- done holding while the request is held, and falling once it is released;
- result and overflow staying stable while done is high;
- overflow only appearing with done and a saturated magnitude;
- a zero exponent field only ever appearing in an all-zero word.

The arithmetic itself can only be shown by the bench's scenarios:
- the sign, exponent and truncated fraction values;
- the zero-operand, underflow and overflow classes;
- the capture of operands at acceptance.

For these, the bench sweeps exponent corners, fraction patterns and signs against products computed independently.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_NORM,
    ST_PACK,
    ST_HOLD
  } fpm_state_e;

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic load,
  output logic mul_en,
  output logic norm_en,
  output logic pack_en,
  output logic done
);

  fpm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req) st_d = ST_MUL;
      ST_MUL:  st_d = ST_NORM;
      ST_NORM: st_d = ST_PACK;
      ST_PACK: st_d = ST_HOLD;
      ST_HOLD: if (!req) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign load    = (st_q == ST_IDLE) && req;
  assign mul_en  = (st_q == ST_MUL);
  assign norm_en = (st_q == ST_NORM);
  assign pack_en = (st_q == ST_PACK);
  assign done    = (st_q == ST_HOLD);

endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int BIAS   = 128
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic                         mul_en,
  input  logic [EXP_W+FRAC_W:0]        a,
  input  logic [EXP_W+FRAC_W:0]        b,
  output logic                         sgn,
  output logic                         zero,
  output logic signed [EXP_W+2:0]      esum,
  output logic [FRAC_W+1:0]            prod_hi
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EWIDE  = EXP_W + 3;
  localparam int PAD    = EWIDE - EXP_W;
  localparam int HI_W   = FRAC_W + 2;
  localparam logic signed [EWIDE-1:0] BIAS_S = EWIDE'(BIAS);

  logic [WORD_W-1:0] op [2];
  logic [SIG_W-1:0]  sig  [2];
  logic [EWIDE-1:0]  ewid [2];
  logic [1:0]        opz;

  assign op[0] = a;
  assign op[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    assign sig[i]  = {1'b1, op[i][FRAC_W-1:0]};
    assign ewid[i] = {{PAD{1'b0}}, op[i][WORD_W-2:FRAC_W]};
    assign opz[i]  = (op[i][WORD_W-2:0] == '0);
  end

  logic [SIG_W-1:0]  sa_q, sb_q;
  logic [PROD_W-1:0] full;
  logic [PROD_W-HI_W-1:0] unused_low;

  assign full       = sa_q * sb_q;
  assign unused_low = full[PROD_W-HI_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sgn     <= 1'b0;
      zero    <= 1'b0;
      esum    <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      prod_hi <= '0;
    end else begin
      if (load) begin
        sgn  <= op[0][WORD_W-1] ^ op[1][WORD_W-1];
        zero <= |opz;
        esum <= $signed(ewid[0]) + $signed(ewid[1]) - BIAS_S;
        sa_q <= sig[0];
        sb_q <= sig[1];
      end
      if (mul_en) prod_hi <= full[PROD_W-1 -: HI_W];
    end
  end

endmodule

// File: rtl/fpm_norm.sv
module fpm_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    norm_en,
  input  logic                    pack_en,
  input  logic                    sgn,
  input  logic                    zero,
  input  logic signed [EXP_W+2:0] esum,
  input  logic [FRAC_W+1:0]       prod_hi,
  output logic [EXP_W+FRAC_W:0]   res,
  output logic                    sat
);

  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int EWIDE   = EXP_W + 3;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic signed [EWIDE-1:0] EMAX_S = EWIDE'(EXP_MAX);
  localparam logic signed [EWIDE-1:0] ONE_S  = EWIDE'(1);

  logic                    top;
  logic [FRAC_W-1:0]       mant_d, mant_q;
  logic signed [EWIDE-1:0] exp_d, exp_q;
  logic                    sgn_q, zero_q;

  assign top    = prod_hi[FRAC_W+1];
  assign mant_d = top ? prod_hi[FRAC_W:1] : prod_hi[FRAC_W-1:0];
  assign exp_d  = top ? (esum + ONE_S) : esum;

  always_ff @(posedge clk) begin
    if (rst) begin
      mant_q <= '0;
      exp_q  <= '0;
      sgn_q  <= 1'b0;
      zero_q <= 1'b0;
      res    <= '0;
      sat    <= 1'b0;
    end else begin
      if (norm_en) begin
        mant_q <= mant_d;
        exp_q  <= exp_d;
        sgn_q  <= sgn;
        zero_q <= zero;
      end
      if (pack_en) begin
        if (zero_q || exp_q < ONE_S) begin
          res <= '0;
          sat <= 1'b0;
        end else if (exp_q > EMAX_S) begin
          res <= {sgn_q, {(WORD_W-1){1'b1}}};
          sat <= 1'b1;
        end else begin
          res <= {sgn_q, exp_q[EXP_W-1:0], mant_q};
          sat <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/fpmul_seq.sv
module fpmul_seq #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int BIAS   = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_i,
  input  logic [EXP_W+FRAC_W:0]  a_i,
  input  logic [EXP_W+FRAC_W:0]  b_i,
  output logic [EXP_W+FRAC_W:0]  res_o,
  output logic                   done_o,
  output logic                   ovf_o
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int EWIDE  = EXP_W + 3;

  logic load, mul_en, norm_en, pack_en, done;
  logic sgn, zero, sat;
  logic signed [EWIDE-1:0] esum;
  logic [FRAC_W+1:0] prod_hi;
  logic [WORD_W-1:0] res;

  fpm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req(req_i),
    .load(load), .mul_en(mul_en), .norm_en(norm_en),
    .pack_en(pack_en), .done(done)
  );

  fpm_sigmul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) u_sigmul (
    .clk(clk), .rst(rst), .load(load), .mul_en(mul_en),
    .a(a_i), .b(b_i),
    .sgn(sgn), .zero(zero), .esum(esum), .prod_hi(prod_hi)
  );

  fpm_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk(clk), .rst(rst), .norm_en(norm_en), .pack_en(pack_en),
    .sgn(sgn), .zero(zero), .esum(esum), .prod_hi(prod_hi),
    .res(res), .sat(sat)
  );

  assign res_o  = res;
  assign done_o = done;
  assign ovf_o  = done & sat;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req,
  input logic                  done,
  input logic [EXP_W+FRAC_W:0] res,
  input logic                  ovf
);

  localparam int W = 1 + EXP_W + FRAC_W;

  // R1: outputs cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!done && !ovf && res == '0));

  // R2: done rises only four edges after a request was present
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(req, 4));

  // R3: done holds under a held request
  a_r3_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && req) |=> done);

  // R3: done drops once request is released
  a_r3_done_drop: assert property (@(posedge clk) disable iff (rst)
    (done && !req) |=> !done);

  // R9: result and overflow stay stable while done is held
  a_r9_result_stable: assert property (@(posedge clk) disable iff (rst)
    (done && req) |=> ($stable(res) && $stable(ovf)));

  // R8: overflow only with done and a saturated magnitude
  a_r8_ovf_with_done: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (done && res[W-2:0] == '1));

  // R7: a zero exponent field only in a fully cleared word
  a_r7_zero_clean: assert property (@(posedge clk) disable iff (rst)
    (done && res[W-2:FRAC_W] == '0) |-> (res == '0 && !ovf));

endmodule

bind fpmul_seq fpm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpm_checker (
  .clk(clk), .rst(rst), .req(req_i), .done(done_o), .res(res_o), .ovf(ovf_o)
);

// File: tb/tb_fpmul_seq.sv
module tb_fpmul_seq;

  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] res_o;
  logic        done_o;
  logic        ovf_o;

  int n_cmp = 0;
  int n_bad = 0;

  fpmul_seq dut (
    .clk(clk), .rst(rst), .req_i(req_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // expected {overflow, result} from the requirement arithmetic
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [47:0] p;
    logic [22:0] m;
    int e;
    logic s;
    s = a[31] ^ b[31];
    if (a[30:0] == 0 || b[30:0] == 0) return 33'h0;
    p = {1'b1, a[22:0]} * {1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 128;
    if (p[47]) begin m = p[46:24]; e = e + 1; end
    else m = p[45:23];
    if (e > 255) return {1'b1, s, 31'h7FFFFFFF};
    if (e <= 0) return 33'h0;
    return {1'b0, s, e[7:0], m};
  endfunction

  function automatic string class_tag(input logic [31:0] a, input logic [31:0] b);
    logic [47:0] p;
    int e;
    if (a[30:0] == 0 || b[30:0] == 0) return "R6 zero operand";
    p = {1'b1, a[22:0]} * {1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 128 + (p[47] ? 1 : 0);
    if (e > 255) return "R8 overflow saturate";
    if (e <= 0) return "R7 underflow flush";
    return "R5 R10 normal product";
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] exp_v;
    logic [31:0] held;
    exp_v = model(a, b);
    @(negedge clk);
    a_i = a; b_i = b; req_i = 1'b1;
    @(negedge clk);
    a_i = ~a; b_i = b ^ 32'h5A5A5A5A;   // R10: inputs change after acceptance
    @(negedge clk);
    @(negedge clk);
    check(done_o == 1'b0, "R2 done early", {31'b0, done_o}, 32'h0);
    @(negedge clk);
    check(done_o == 1'b1, "R2 done after four edges", {31'b0, done_o}, 32'h1);
    check(res_o == exp_v[31:0], class_tag(a, b), res_o, exp_v[31:0]);
    check(ovf_o == exp_v[32], "R8 overflow flag", {31'b0, ovf_o}, {31'b0, exp_v[32]});
    if (exp_v[31:0] != 0)
      check(res_o[31] == (a[31] ^ b[31]), "R4 sign", {31'b0, res_o[31]},
            {31'b0, a[31] ^ b[31]});
    held = res_o;
    @(negedge clk);
    check(done_o == 1'b1 && res_o == held && ovf_o == exp_v[32],
          "R3 R9 hold while requested", res_o, held);
    req_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0 && ovf_o == 1'b0, "R3 release", {30'b0, done_o, ovf_o}, 32'h0);
  endtask

  initial begin
    logic [7:0]  exps [12];
    logic [22:0] fracs [4];
    logic [31:0] x;
    exps = '{8'd0, 8'd1, 8'd2, 8'd63, 8'd64, 8'd127, 8'd128, 8'd129,
             8'd191, 8'd192, 8'd254, 8'd255};
    fracs = '{23'h000000, 23'h7FFFFF, 23'h400000, 23'h123456};

    repeat (3) @(negedge clk);
    check(done_o == 0 && ovf_o == 0 && res_o == 0, "R1 reset state", res_o, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    check(done_o == 0 && ovf_o == 0 && res_o == 0, "R1 after reset", res_o, 32'h0);

    // R3: idle block with request low does nothing
    repeat (6) @(negedge clk);
    check(done_o == 1'b0, "R3 idle without request", {31'b0, done_o}, 32'h0);

    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int f = 0; f < 16; f++) begin
          logic sa, sb;
          sa = f[0] ^ i[0];
          sb = f[1] ^ j[1];
          run_op({sa, exps[i], fracs[f % 4]}, {sb, exps[j], fracs[f / 4]});
        end

    x = 32'h1F2E3D4C;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra, rb;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      ra = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      rb = x;
      run_op(ra, rb);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule